// File: doc/BRIEF.md
# I2C Port Expander Target

This block is an I2C target that gives a host control of one eight-pin general-purpose port through four byte-wide registers. A host addresses the target, writes a command byte that picks one register, and then either writes data bytes into that register or, in a later read transfer, reads it back. The selection survives between transfers, so a read always comes from whichever register was last picked. The four registers are: a read-only view of the pins (optionally inverted bit by bit), an output data latch, a per-bit inversion mask, and a per-bit direction control.

The seven-bit target address has six fixed upper bits and a least significant bit taken from a strap input, so two targets can share one bus. SCL and SDA are brought in as plain inputs. The target pulls SDA low through an output enable and never stretches SCL. Both lines, the strap-free port pins and the bus conditions are sampled on a system clock that must run at least eight times faster than SCL. The bus carries its own flow control (acknowledge bits), so the block has no valid/ready pairs: every pin is a plain level.

Top module: `gpio_xpndr_i2c`

## Requirements
- R1: The target acknowledges address 0x20 when `addr_strap_i` is 0 and address 0x21 when it is 1. The address byte is sent MSB first with the direction bit last.
- R2: An address byte that does not match gets no acknowledge, and the target keeps SDA released for all following bytes until the next START; no register changes.
- R3: A direction bit of 0 starts a write transfer whose first byte after the address is a command byte; a direction bit of 1 starts a read transfer that returns the currently selected register.
- R4: After reset the output latch is 0xFF, the inversion mask is 0x00, the direction control is 0xFF and the selection is 0x00, so `port_o` reads 0xFF and `port_oe_o` reads 0x00.
- R5: Command values 0x00 (pin view), 0x01 (output latch), 0x02 (inversion mask) and 0x03 (direction control) select a register; the selection persists across STOP and governs later reads.
- R6: Each acknowledged data byte in a write transfer is stored into the selected read/write register; several data bytes in one transfer all go to that register and the last one remains.
- R7: A command byte from 0x04 to 0xFF is acknowledged, leaves the selection unchanged, and any data bytes that follow in the same transfer are acknowledged and discarded.
- R8: A data byte written while the pin view (0x00) is selected is acknowledged and changes no register.
- R9: A read of the pin view returns the synchronised pin levels XORed bit by bit with the inversion mask.
- R10: For each bit, a direction-control value of 1 makes `port_oe_o` 0; a value of 0 makes `port_oe_o` 1. `port_o` always equals the output latch.
- R11: A repeated START restarts at the address byte within the same transfer; a STOP ends the transfer and leaves SDA released.
- R12: Read data is shifted out MSB first, the target changes its SDA drive only while SCL is low, and a master acknowledge (SDA low) after a read byte makes the target send the same register again, while a not-acknowledge ends its driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| addr_strap_i | input | 1 | Sets the address LSB |
| port_i | input | 8 | Port pin levels |
| port_o | output | 8 | Output latch value for the pins |
| port_oe_o | output | 8 | 1 enables the pin driver for that bit |

## Verification
On every cycle the assertions hold that SDA drive is released one cycle after a STOP, that the target's SDA drive never changes during a high phase of SCL, that a register write happens only while SCL is low, that a write aimed at the pin view leaves all three writable registers unchanged, and that reset leaves the power-up values. Address matching with both strap values, the silence after a wrong address, the stored selection across transfers, discarded data after an invalid command, the inversion applied to pin reads, repeated START and multi-byte reads with master acknowledge can only be shown by the bench's transfer sequences, which compare each acknowledge bit, read byte and port value against values worked out from the requirements.

// File: rtl/gx_pkg.sv
package gx_pkg;
  // position within one transfer
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  // register selection carried by the command byte
  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_INV  = 2'd2,
    SEL_DIR  = 2'd3
  } sel_t;

  // upper six address bits; strap supplies the seventh
  localparam logic [5:0] ADDR_FIXED = 6'b010000;
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= INIT;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gx_bus_cond.sv
module gx_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  // SDA edges while SCL stays high mark the bus conditions
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/gx_engine.sv
module gx_engine
  import gx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output sel_t          sel
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] BYTE_END = CW'(DW);
  localparam logic [CW-1:0] ACK_END  = CW'(DW + 1);

  phase_t        phase;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] sr, tx;
  logic          rw, wr_ok;
  logic          active, addr_hit, cmd_ok;

  assign active   = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign addr_hit = sr[DW-1:1] == {ADDR_FIXED, strap};
  assign cmd_ok   = sr[DW-1:2] == '0;
  assign wr_data  = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitcnt <= '0;
      sr     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      wr_ok  <= 1'b0;
      sda_oe <= 1'b0;
      wr_en  <= 1'b0;
      sel    <= SEL_PINS;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        wr_ok  <= 1'b0;
      end else if (scl_rise && active) begin
        if (bitcnt < BYTE_END) sr <= {sr[DW-2:0], sda_s};
        else if (phase == PH_RDATA && sda_s) phase <= PH_SKIP; // master NACK
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall && active) begin
        if (bitcnt == BYTE_END) begin
          unique case (phase)
            PH_ADDR: begin
              rw <= sr[0];
              if (addr_hit) sda_oe <= 1'b1;
              else          phase  <= PH_SKIP;
            end
            PH_CMD: begin
              sda_oe <= 1'b1;
              wr_ok  <= cmd_ok;
              if (cmd_ok) sel <= sel_t'(sr[1:0]);
            end
            PH_WDATA: begin
              sda_oe <= 1'b1;
              wr_en  <= wr_ok;
            end
            default: sda_oe <= 1'b0;   // read byte done, master answers
          endcase
        end else if (bitcnt == ACK_END) begin
          bitcnt <= '0;
          if ((phase == PH_ADDR && rw) || phase == PH_RDATA) begin
            phase  <= PH_RDATA;
            sda_oe <= !rd_data[DW-1];
            tx     <= {rd_data[DW-2:0], 1'b0};
          end else begin
            sda_oe <= 1'b0;
            if (phase == PH_ADDR)     phase <= PH_CMD;
            else if (phase == PH_CMD) phase <= PH_WDATA;
          end
        end else if (phase == PH_RDATA) begin
          sda_oe <= !tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R12
endmodule

// File: rtl/gx_regfile.sv
module gx_regfile
  import gx_pkg::*;
#(
  parameter int           DW      = 8,
  parameter logic [DW-1:0] OUT_RST = '1,
  parameter logic [DW-1:0] INV_RST = '0,
  parameter logic [DW-1:0] DIR_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  sel_t          sel,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pins_s,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] port_out,
  output logic [DW-1:0] port_oe
);
  logic [DW-1:0] out_q, inv_q, dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RST;
      inv_q <= INV_RST;
      dir_q <= DIR_RST;
    end else if (wr_en) begin
      unique case (sel)
        SEL_OUT: out_q <= wr_data;
        SEL_INV: inv_q <= wr_data;
        SEL_DIR: dir_q <= wr_data;
        default: ;                    // pin view is read-only
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_OUT: rd_data = out_q;
      SEL_INV: rd_data = inv_q;
      SEL_DIR: rd_data = dir_q;
      default: rd_data = pins_s ^ inv_q;
    endcase
  end

  assign port_out = out_q;
  for (genvar b = 0; b < DW; b++) begin : g_pin
    assign port_oe[b] = !dir_q[b];
  end

  AST_POWERUP_VALUES: assert property (@(posedge clk)
    !rst_n |=> (out_q == OUT_RST && inv_q == INV_RST && dir_q == DIR_RST)); // R4
  AST_PIN_VIEW_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PINS) |=> $stable({out_q, inv_q, dir_q})); // R8
endmodule

// File: rtl/gpio_xpndr_i2c.sv
module gpio_xpndr_i2c
  import gx_pkg::*;
#(
  parameter int          PORT_W      = 8,   // equals the bus byte width
  parameter int          SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] OUT_RST = '1,
  parameter logic [PORT_W-1:0] INV_RST = '0,
  parameter logic [PORT_W-1:0] DIR_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_strap_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [PORT_W-1:0] port_o,
  output logic [PORT_W-1:0] port_oe_o
);
  logic              scl_s, sda_s;
  logic [PORT_W-1:0] pins_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PORT_W-1:0] wr_data, rd_data;
  sel_t              sel;

  gx_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  gx_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .INIT('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(port_i), .q(pins_s));

  gx_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  gx_engine #(.DW(PORT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .strap(addr_strap_i),
    .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_data(wr_data), .sel(sel));

  gx_regfile #(.DW(PORT_W), .OUT_RST(OUT_RST), .INV_RST(INV_RST), .DIR_RST(DIR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .pins_s(pins_s), .rd_data(rd_data),
    .port_out(port_o), .port_oe(port_oe_o));

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o); // R11
  AST_WRITE_IN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s); // R6
endmodule

// File: tb/gpio_xpndr_i2c_tb_top.sv
`timescale 1ns/1ps
module gpio_xpndr_i2c_tb_top;
  localparam int Q = 40;   // quarter of an SCL period in ns
  localparam int H = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_low = 1'b0;
  logic       strap = 1'b0;
  logic [7:0] pins = 8'hA5;
  logic       sda_oe;
  logic [7:0] port_o, port_oe;
  wire        sda_w = !(sda_low || sda_oe);

  gpio_xpndr_i2c dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .addr_strap_i(strap), .port_i(pins), .port_o(port_o), .port_oe_o(port_oe));

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic expect_v(string tag, logic [7:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (obs_q.size() > 0);
      begin
        logic [7:0] got;
        item_t it;
        got = obs_q.pop_front();
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected result: actual %h expected none", got);
        end else begin
          it = exp_q.pop_front();
          if (got !== it.val) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, got, it.val);
          end
        end
      end
    end
  end

  task automatic bus_start;
    sda_low = 1'b0; #Q; scl_m = 1'b1; #Q; sda_low = 1'b1; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic bus_stop;
    sda_low = 1'b1; #Q; scl_m = 1'b1; #Q; sda_low = 1'b0; #Q;
  endtask
  task automatic put_bit(input logic b);
    sda_low = !b; #Q; scl_m = 1'b1; #H; scl_m = 1'b0; #Q;
  endtask
  task automatic get_bit(output logic b);
    sda_low = 1'b0; #Q; scl_m = 1'b1; #Q; b = sda_w; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic wr_byte(input logic [7:0] d);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    obs_q.push_back({7'b0, a});
  endtask
  task automatic rd_byte(input logic nack);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
    obs_q.push_back(d);
  endtask
  task automatic look(input logic [7:0] v);
    obs_q.push_back(v);
  endtask
  // write transfer: address 0x20, command, optional data byte
  task automatic wr_xfer(input logic [7:0] cmd, input bit has_data, input logic [7:0] d, string tag);
    bus_start;
    expect_v({tag, " addr ack"}, 8'h00); wr_byte(8'h40);
    expect_v({tag, " cmd ack"}, 8'h00);  wr_byte(cmd);
    if (has_data) begin expect_v({tag, " data ack"}, 8'h00); wr_byte(d); end
    bus_stop; #200;
  endtask
  task automatic rd_xfer(input logic [7:0] v, string tag);
    bus_start;
    expect_v({tag, " addr ack"}, 8'h00); wr_byte(8'h41);
    expect_v({tag, " read data"}, v);    rd_byte(1'b1);
    bus_stop; #200;
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run;
  end

  initial begin
    #100; rst_n = 1'b1; #100;
    // R4: power-up values at the pins
    expect_v("R4 port_o reset", 8'hFF); look(port_o);
    expect_v("R4 port_oe reset", 8'h00); look(port_oe);
    // R3 R9 R5: read with default selection returns pins
    rd_xfer(8'hA5, "R3 R9 default pin read");
    expect_v("R11 SDA released after STOP", 8'h01); look({7'b0, sda_w});
    // R2: wrong address, silence until next START
    bus_start;
    expect_v("R2 address nack", 8'h01); wr_byte(8'h42);
    expect_v("R2 later byte nack", 8'h01); wr_byte(8'h01);
    expect_v("R2 later byte nack", 8'h01); wr_byte(8'h00);
    bus_stop; #200;
    expect_v("R2 port_o unchanged", 8'hFF); look(port_o);
    // R6: output latch
    wr_xfer(8'h01, 1'b1, 8'h3C, "R6");
    expect_v("R6 port_o", 8'h3C); look(port_o);
    // R10: direction control
    wr_xfer(8'h03, 1'b1, 8'hF0, "R10");
    expect_v("R10 port_oe", 8'h0F); look(port_oe);
    expect_v("R10 port_o", 8'h3C); look(port_o);
    // R5: selection persists into a read transfer
    rd_xfer(8'hF0, "R5 dir readback");
    // R9: inversion applied to pin view
    wr_xfer(8'h02, 1'b1, 8'hFF, "R9");
    wr_xfer(8'h00, 1'b0, 8'h00, "R9 select pins");
    rd_xfer(8'h5A, "R9 inverted pins");
    // R7: invalid command ignored, following data dropped
    wr_xfer(8'h07, 1'b1, 8'h11, "R7");
    rd_xfer(8'h5A, "R7 selection kept");
    expect_v("R7 port_o", 8'h3C); look(port_o);
    expect_v("R7 port_oe", 8'h0F); look(port_oe);
    // R8: write to pin view discarded
    wr_xfer(8'h00, 1'b1, 8'h00, "R8");
    rd_xfer(8'h5A, "R8 pins still inverted");
    // R11: repeated START into a read of the inversion mask
    bus_start;
    expect_v("R11 addr ack", 8'h00); wr_byte(8'h40);
    expect_v("R11 cmd ack", 8'h00);  wr_byte(8'h02);
    bus_start;
    expect_v("R11 read addr ack", 8'h00); wr_byte(8'h41);
    expect_v("R11 R8 mask unchanged", 8'hFF); rd_byte(1'b1);
    bus_stop; #200;
    // R1: strap high moves the address
    strap = 1'b1; #100;
    bus_start;
    expect_v("R1 old address nack", 8'h01); wr_byte(8'h40);
    bus_stop; #200;
    bus_start;
    expect_v("R1 addr ack", 8'h00); wr_byte(8'h42);
    expect_v("R1 cmd ack", 8'h00);  wr_byte(8'h01);
    expect_v("R6 data ack", 8'h00); wr_byte(8'h81);
    expect_v("R6 data ack", 8'h00); wr_byte(8'h42);
    bus_stop; #200;
    expect_v("R6 last byte kept", 8'h42); look(port_o);
    // R12: multi-byte read with master acknowledge
    bus_start;
    expect_v("R12 addr ack", 8'h00); wr_byte(8'h43);
    expect_v("R12 first byte", 8'h42); rd_byte(1'b0);
    expect_v("R12 second byte", 8'h42); rd_byte(1'b1);
    bus_stop; #200;
    expect_v("R12 SDA released", 8'h01); look({7'b0, sda_w});
    wait (obs_q.size() == 0);
    #20;
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run;
  end
endmodule